// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block turns a system clock into the timing of one SPI frame: the serial clock line, the window during which the chip select is asserted, and one-cycle strobes that mark where the data path should sample the incoming bit and shift out the next one. All its timing comes from one 24-bit timing word. Each of the four intervals (bit cell, lead delay, trailing delay and the gap after a transfer) is set by a small prescaler code multiplied by a scaler code. The prescaler values are not powers of two, so a wide range of rates comes from few bits.

A frame begins when `start` is seen high while the block is idle. At that edge the timing word, the frame-size code, polarity and phase are captured and then held for the whole frame. The frame asserts chip select, waits the lead delay with the clock at its idle level, and runs one bit cell per data bit. It then waits the trailing delay with chip select still asserted, negates chip select for the after-transfer gap, and finally pulses `done` for one cycle as it returns to idle. Software chooses the codes. Working out codes from a wanted frequency or delay is not part of the block.

Top module: `sck_frame_timer`

## Requirements
- R1: While reset is asserted and after its release with no start, `cs_active`, `sample_stb`, `shift_stb` and `done` are 0 and `sck` equals the `cpol` input.
- R2: A bit cell lasts P = Bp x Bs system clocks, split into two halves of P/2 cycles. Bp is selected by timing_word[17:16] (codes 0,1,2,3 give 2,3,5,7). Bs is selected by timing_word[3:0]: codes 0..3 give 2,4,6,8 and codes n of 4..15 give 2^n.
- R3: The lead delay lasts (2c+1) x 2^(n+1) cycles, with c = timing_word[23:22] and n = timing_word[15:12]. It starts in the cycle after start is accepted. During it `cs_active` is 1 and `sck` stays at the latched polarity.
- R4: The trailing delay follows the last bit cell. Its length uses the same formula with c = timing_word[21:20] and n = timing_word[11:8]. During it `cs_active` stays 1 and `sck` is at the latched polarity.
- R5: The after-transfer gap follows the trailing delay. Its length uses the same formula with c = timing_word[19:18] and n = timing_word[7:4]. During it `cs_active` is 0 and `sck` is at the latched polarity.
- R6: In the first half of each bit cell `sck` equals cpol XOR cpha, and in the second half it is the inverse. In idle `sck` follows the live `cpol` input.
- R7: `sample_stb` is high for exactly the first cycle of the second half of each bit cell, and never together with `shift_stb`.
- R8: `shift_stb` is high for the first cycle of the first half of every bit cell. The only exception is the first bit cell of a frame when cpha = 0.
- R9: A frame has frame_code + 1 bit cells (1 to 16), and strobes occur only while `cs_active` is 1.
- R10: `done` is high for one cycle right after the gap, when the block is idle again. A start seen while a frame is running is ignored, and a start held high starts the next frame in the cycle `done` is high.
- R11: The timing word, frame code, cpol and cpha are captured when start is accepted. Changing these inputs during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; accepted only when idle |
| timing_word | input | 24 | Prescaler and scaler codes for bit cell and the three delays |
| frame_code | input | 4 | Number of bits in the frame minus one |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on the first edge of a cell, 1: on the second |
| sck | output | 1 | Serial clock line |
| cs_active | output | 1 | Chip select asserted (active high) |
| sample_stb | output | 1 | One-cycle strobe at each sampling edge |
| shift_stb | output | 1 | One-cycle strobe at each shifting edge |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions take all inputs to be synchronous to `clk`. They assume nothing about the codes, since every code value gives a legal length. The edge checks for `sample_stb` and `shift_stb` depend on each half cell lasting at least two cycles, and this holds for every code because the shortest cell is four cycles. The stimulus changes inputs only at the falling clock edge. It covers all four polarity and phase pairs, single-bit and multi-bit frames, and both the shortest and long cells and delays. It also holds start high across frames and rewrites the timing word and frame code in mid-frame, so that the capture rule and the ignored-start rule are exercised.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int WORD_W = 24;
  localparam int CNT_W  = 19;
  localparam int NDLY   = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_BITS  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;

  function automatic logic [CNT_W-1:0] baud_pre_val(input logic [1:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      2'd0:    v = CNT_W'(2);
      2'd1:    v = CNT_W'(3);
      2'd2:    v = CNT_W'(5);
      default: v = CNT_W'(7);
    endcase
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] baud_scale_val(input logic [3:0] code);
    logic [CNT_W-1:0] v;
    if (code < 4'd4) v = CNT_W'({code, 1'b0}) + CNT_W'(2);
    else             v = CNT_W'(1) << code;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] delay_len(input logic [1:0] pre, input logic [3:0] sc);
    logic [CNT_W-1:0] odd;
    odd = CNT_W'({pre, 1'b1});
    return odd << (CNT_W'(sc) + CNT_W'(1));
  endfunction

endpackage

// File: rtl/sft_decode.sv
module sft_decode
  import sft_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  half_len,
  output logic [CNT_W-1:0]  lead_len,
  output logic [CNT_W-1:0]  trail_len,
  output logic [CNT_W-1:0]  gap_len
);

  localparam int PRE_TOP = 23;
  localparam int SC_TOP  = 15;

  logic [CNT_W-1:0] dly [NDLY];
  logic [CNT_W-1:0] period;

  genvar gi;
  generate
    for (gi = 0; gi < NDLY; gi++) begin : g_dly
      assign dly[gi] = delay_len(word[PRE_TOP - 2*gi -: 2], word[SC_TOP - 4*gi -: 4]);
    end
  endgenerate

  always_comb begin
    period   = baud_pre_val(word[17:16]) * baud_scale_val(word[3:0]);
    half_len = period >> 1;
  end

  assign lead_len  = dly[0];
  assign trail_len = dly[1];
  assign gap_len   = dly[2];

endmodule

// File: rtl/sft_seq.sv
module sft_seq
  import sft_pkg::*;
#(
  parameter int FRAME_CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W-1:0]       word_in,
  input  logic [FRAME_CODE_W-1:0] code_in,
  input  logic                    cpol_in,
  input  logic                    cpha_in,
  input  logic [CNT_W-1:0]        lead_live,
  input  logic [CNT_W-1:0]        half_len,
  input  logic [CNT_W-1:0]        trail_len,
  input  logic [CNT_W-1:0]        gap_len,
  output logic [WORD_W-1:0]       word_q,
  output logic                    sck,
  output logic                    cs_active,
  output logic                    sample_stb,
  output logic                    shift_stb,
  output logic                    done
);

  localparam logic [CNT_W-1:0]        CNT_ONE  = CNT_W'(1);
  localparam logic [FRAME_CODE_W-1:0] BITS_ONE = FRAME_CODE_W'(1);

  seq_state_t              state_q, state_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [FRAME_CODE_W-1:0] bits_q, bits_d;
  logic                    half_q, half_d;
  logic                    sample_q, sample_d;
  logic                    shift_q, shift_d;
  logic                    done_q, done_d;
  logic                    cap_en;
  logic [FRAME_CODE_W-1:0] code_q;
  logic                    cpol_q, cpha_q;
  logic                    cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bits_d   = bits_q;
    half_d   = half_q;
    sample_d = 1'b0;
    shift_d  = 1'b0;
    done_d   = 1'b0;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_LEAD;
          cnt_d   = lead_live - CNT_ONE;
        end
      end
      ST_LEAD: begin
        if (cnt_zero) begin
          state_d = ST_BITS;
          half_d  = 1'b0;
          cnt_d   = half_len - CNT_ONE;
          bits_d  = code_q;
          shift_d = cpha_q;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      ST_BITS: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_ONE;
        end else if (!half_q) begin
          half_d   = 1'b1;
          cnt_d    = half_len - CNT_ONE;
          sample_d = 1'b1;
        end else if (bits_q == '0) begin
          state_d = ST_TRAIL;
          half_d  = 1'b0;
          cnt_d   = trail_len - CNT_ONE;
        end else begin
          bits_d  = bits_q - BITS_ONE;
          half_d  = 1'b0;
          cnt_d   = half_len - CNT_ONE;
          shift_d = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (cnt_zero) begin
          state_d = ST_GAP;
          cnt_d   = gap_len - CNT_ONE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      ST_GAP: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bits_q   <= '0;
      half_q   <= 1'b0;
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bits_q   <= bits_d;
      half_q   <= half_d;
      sample_q <= sample_d;
      shift_q  <= shift_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      code_q <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else if (cap_en) begin
      word_q <= word_in;
      code_q <= code_in;
      cpol_q <= cpol_in;
      cpha_q <= cpha_in;
    end
  end

  always_comb begin
    if (state_q == ST_IDLE)      sck = cpol_in;
    else if (state_q == ST_BITS) sck = cpol_q ^ cpha_q ^ half_q;
    else                         sck = cpol_q;
  end

  assign cs_active  = (state_q == ST_LEAD) || (state_q == ST_BITS) || (state_q == ST_TRAIL);
  assign sample_stb = sample_q;
  assign shift_stb  = shift_q;
  assign done       = done_q;

endmodule

// File: rtl/sck_frame_timer.sv
module sck_frame_timer
  import sft_pkg::*;
#(
  parameter int FRAME_CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W-1:0]       timing_word,
  input  logic [FRAME_CODE_W-1:0] frame_code,
  input  logic                    cpol,
  input  logic                    cpha,
  output logic                    sck,
  output logic                    cs_active,
  output logic                    sample_stb,
  output logic                    shift_stb,
  output logic                    done
);

  logic [WORD_W-1:0] held_word;
  logic [CNT_W-1:0]  live_half, live_lead, live_trail, live_gap;
  logic [CNT_W-1:0]  held_half, held_lead, held_trail, held_gap;

  sft_decode u_dec_live (
    .word      (timing_word),
    .half_len  (live_half),
    .lead_len  (live_lead),
    .trail_len (live_trail),
    .gap_len   (live_gap)
  );

  sft_decode u_dec_held (
    .word      (held_word),
    .half_len  (held_half),
    .lead_len  (held_lead),
    .trail_len (held_trail),
    .gap_len   (held_gap)
  );

  sft_seq #(.FRAME_CODE_W(FRAME_CODE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_in    (timing_word),
    .code_in    (frame_code),
    .cpol_in    (cpol),
    .cpha_in    (cpha),
    .lead_live  (live_lead),
    .half_len   (held_half),
    .trail_len  (held_trail),
    .gap_len    (held_gap),
    .word_q     (held_word),
    .sck        (sck),
    .cs_active  (cs_active),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .done       (done)
  );

  logic unused_ok;
  assign unused_ok = ^{live_half, live_trail, live_gap, held_lead};

endmodule

// File: rtl/sck_frame_timer_chk.sv
module sck_frame_timer_chk
  import sft_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              cs_active,
  input logic              sample_stb,
  input logic              shift_stb,
  input logic              done,
  input logic [WORD_W-1:0] word_q
);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cs_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs_active);

  assert_sample_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sck != $past(sck)));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  assert_shift_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (sck != $past(sck)));

  assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> cs_active);

  assert_word_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active)) |-> $stable(word_q));

endmodule

bind sck_frame_timer sck_frame_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .cs_active  (cs_active),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .done       (done),
  .word_q     (held_word)
);

// File: tb/sck_frame_timer_bench.sv
`timescale 1ns/1ps
module sck_frame_timer_bench;

  typedef struct packed {
    logic live;
    logic cs;
    logic sck;
    logic smp;
    logic sh;
    logic dn;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] timing_word;
  logic [3:0]  frame_code;
  logic        cpol;
  logic        cpha;
  logic        sck, cs_active, sample_stb, shift_stb, done;

  int   n_cmp;
  int   n_bad;
  int   cycles;
  string cur_req;
  exp_t q[$];

  sck_frame_timer u_sck_frame_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .timing_word(timing_word),
    .frame_code(frame_code), .cpol(cpol), .cpha(cpha), .sck(sck),
    .cs_active(cs_active), .sample_stb(sample_stb), .shift_stb(shift_stb), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [23:0] mk(int lp, int tp, int gp, int bp, int ls, int ts, int gs, int bs);
    return {2'(lp), 2'(tp), 2'(gp), 2'(bp), 4'(ls), 4'(ts), 4'(gs), 4'(bs)};
  endfunction

  function automatic int bpre(int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int bscl(int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction

  function automatic int dly(int p, int s);
    return (2 * p + 1) * (2 << s);
  endfunction

  task automatic push(int n, logic c, logic s);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      e = '{live: 1'b0, cs: c, sck: s, smp: 1'b0, sh: 1'b0, dn: 1'b0};
      q.push_back(e);
    end
  endtask

  task automatic build(logic [23:0] w, int code, logic pl, logic ph);
    int   half;
    exp_t e;
    half = bpre(int'(w[17:16])) * bscl(int'(w[3:0])) / 2;
    push(dly(int'(w[23:22]), int'(w[15:12])), 1'b1, pl);
    for (int b = 0; b <= code; b++) begin
      for (int i = 0; i < half; i++) begin
        e = '{live: 1'b0, cs: 1'b1, sck: pl ^ ph, smp: 1'b0,
              sh: (i == 0) && (ph || b > 0), dn: 1'b0};
        q.push_back(e);
      end
      for (int i = 0; i < half; i++) begin
        e = '{live: 1'b0, cs: 1'b1, sck: ~(pl ^ ph), smp: (i == 0), sh: 1'b0, dn: 1'b0};
        q.push_back(e);
      end
    end
    push(dly(int'(w[21:20]), int'(w[11:8])), 1'b1, pl);
    push(dly(int'(w[19:18]), int'(w[7:4])), 1'b0, pl);
    e = '{live: 1'b1, cs: 1'b0, sck: 1'b0, smp: 1'b0, sh: 1'b0, dn: 1'b1};
    q.push_back(e);
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic accept;
    if (!rst_n) begin
      q.delete();
    end else begin
      accept = start && ((q.size() == 0) || q[0].live);
      if (q.size() > 0) void'(q.pop_front());
      if (accept) build(timing_word, int'(frame_code), cpol, cpha);
    end
  end

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // comparison one nanosecond before each rising edge
  always begin
    exp_t e;
    logic es;
    @(posedge clk);
    #3;
    if (q.size() > 0) e = q[0];
    else e = '{live: 1'b1, cs: 1'b0, sck: 1'b0, smp: 1'b0, sh: 1'b0, dn: 1'b0};
    es = e.live ? cpol : e.sck;
    n_cmp++;
    if (cs_active !== e.cs || sck !== es || sample_stb !== e.smp ||
        shift_stb !== e.sh || done !== e.dn) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got cs=%b sck=%b smp=%b sh=%b dn=%b expected cs=%b sck=%b smp=%b sh=%b dn=%b",
               cur_req, cycles, cs_active, sck, sample_stb, shift_stb, done,
               e.cs, es, e.smp, e.sh, e.dn);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected below 150000", cycles);
      finish_up();
    end
  end

  task automatic idle_wait(int extra);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  task automatic run_frame(logic [23:0] w, int code, logic pl, logic ph);
    @(negedge clk);
    timing_word = w;
    frame_code  = 4'(code);
    cpol        = pl;
    cpha        = ph;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle_wait(3);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cycles = 0;
    rst_n = 1'b0; start = 1'b0; timing_word = '0; frame_code = '0;
    cpol = 1'b0; cpha = 1'b0;
    cur_req = "R1 reset";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R2 R9 shortest cell, 8 bits, mode 0";
    run_frame(mk(0, 0, 0, 0, 0, 0, 0, 0), 7, 1'b0, 1'b0);

    cur_req = "R6 R7 R8 cpol=1 cpha=1";
    run_frame(mk(0, 1, 0, 2, 1, 0, 0, 1), 3, 1'b1, 1'b1);

    cur_req = "R3 R4 R5 delays, cpol=1 cpha=0";
    run_frame(mk(3, 1, 2, 1, 2, 0, 1, 2), 2, 1'b1, 1'b0);

    cur_req = "R2 R8 R9 one-bit frame cpha=1";
    run_frame(mk(1, 2, 3, 3, 0, 1, 0, 4), 0, 1'b0, 1'b1);

    cur_req = "R2 R9 sixteen bits";
    run_frame(mk(0, 0, 0, 1, 0, 0, 0, 3), 15, 1'b0, 1'b1);

    cur_req = "R10 R11 held start, mid-frame rewrites";
    @(negedge clk);
    timing_word = mk(1, 0, 0, 0, 1, 1, 0, 1);
    frame_code = 4'd2; cpol = 1'b0; cpha = 1'b0; start = 1'b1;
    repeat (12) @(negedge clk);
    timing_word = mk(2, 3, 1, 2, 0, 0, 2, 0);
    frame_code = 4'd4; cpha = 1'b1;
    repeat (40) @(negedge clk);
    timing_word = mk(0, 0, 0, 0, 0, 0, 0, 0);
    frame_code = 4'd1;
    repeat (150) @(negedge clk);
    start = 1'b0;
    idle_wait(3);

    cur_req = "R2 long cell";
    run_frame(mk(0, 0, 0, 3, 0, 0, 0, 6), 1, 1'b1, 1'b1);

    cur_req = "R6 R1 idle follows cpol";
    repeat (3) begin
      @(negedge clk); cpol = ~cpol;
      @(negedge clk);
    end

    cur_req = "R3 R4 R5 long delays";
    run_frame(mk(2, 3, 1, 0, 5, 4, 6, 0), 0, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule